// File: doc/BRIEF.md
# Active Priority Stack with Preemption Grouping

This block keeps, for one processor, the record of which preemption levels are in service and from it the running priority. The interrupt controller offers it the most urgent pending source (ID, 8-bit priority, group) when the processor reads the acknowledge register. The block answers in the same cycle with the ID, or with the spurious ID 1023 when the interrupt cannot be taken. On acceptance it marks the interrupt's preemption level in the active bitmap of that interrupt's group and raises the running priority to the interrupt's group priority.

An end-of-interrupt write clears the most urgent active level of the named group. The running priority is then rebuilt from the lowest set bit of both bitmaps together. A common binary point, and a second binary point used for Group 1 interrupts, decide how many of the priority bits take part in preemption. Lower numbers are more urgent throughout. Clearing the source's pending state and the register views seen from different security states are handled elsewhere.

Top module: `active_prio_stack`

## Requirements
- R1: After reset the running priority is 0x100 (idle), both active bitmaps are zero, the common binary point is MIN_BPR and the Group 1 binary point is MIN_BPR+1.
- R2: An acknowledge is accepted when pend_id < 1020 and pend_prio (zero-extended to 9 bits) is strictly below the running priority. ack_id then equals pend_id in that same cycle, and from the next cycle the running priority equals the group priority and the level bit is set in the selected bitmap.
- R3: A refused acknowledge gives ack_id = 1023 and changes no state. ack_id is also 1023 whenever ack_req is low.
- R4: The group priority is pend_prio AND (0xFF shifted left by bp+1), so bp=7 keeps no bits. Its preemption level is the group priority shifted right by MIN_BPR+1, used as a bit index with bit 0 the most urgent. bp is the Group 1 binary point when groups_en=1, cbpr=0 and the group is 1; otherwise it is the common binary point.
- R5: The effective group is the supplied group bit ANDed with groups_en. Effective group 0 uses act_g0 and effective group 1 uses act_g1, both for activation and for end-of-interrupt.
- R6: An end-of-interrupt takes its ID from eoi_data[9:0]. When accepted, it clears the lowest set bit of the selected group's bitmap, and leaves the bitmap unchanged if it is empty.
- R7: After an accepted end-of-interrupt, the running priority is the index of the lowest set bit of act_g0 OR act_g1, shifted left by MIN_BPR+1, or 0x100 when both bitmaps are empty.
- R8: An end-of-interrupt is ignored when its ID is NUM_SRC or above, or when the running priority is 0x100.
- R9: A binary point write keeps bp_wdata[2:0] and raises it to the floor if lower: MIN_BPR for the common point (bp_sel=0), MIN_BPR+1 for the Group 1 point (bp_sel=1).
- R10: When ack_req and eoi_req are both high in a cycle, the end-of-interrupt is dropped and only the acknowledge is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| groups_en | input | 1 | Interrupt grouping enabled |
| cbpr | input | 1 | Use the common binary point for Group 1 too |
| ack_req | input | 1 | Acknowledge request strobe |
| pend_id | input | 10 | ID of the most urgent pending interrupt |
| pend_prio | input | 8 | Priority of that interrupt |
| pend_grp | input | 1 | Group of that interrupt |
| ack_id | output | 10 | Returned ID, 1023 when refused |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Written word, ID in bits 9:0 |
| eoi_grp | input | 1 | Group of the completed interrupt |
| bp_we | input | 1 | Binary point write strobe |
| bp_sel | input | 1 | 0 common point, 1 Group 1 point |
| bp_wdata | input | 32 | Binary point write data |
| run_prio | output | 9 | Running priority, 0x100 idle |
| bpr_cur | output | 3 | Common binary point |
| abpr_cur | output | 3 | Group 1 binary point |
| act_g0 | output | LEVELS | Group 0 active bitmap |
| act_g1 | output | LEVELS | Group 1 active bitmap |

## Verification
The bench targets an acknowledge whose priority equals the running priority, which a design using a non-strict compare would wrongly accept. It also covers IDs 1020 to 1023, which must be refused, and a binary point of 7, where a design that gets the shift width wrong would keep priority bits. It covers the cbpr override and grouping switched off, where a wrong binary point or bitmap choice shows up as the wrong level or the wrong group. Finally it drives end-of-interrupt writes with an out-of-range ID, while idle, and in the same cycle as an acknowledge; a design that rebuilds the running priority from one group's bitmap only, or that clears the highest set bit, drifts from the bench model during random nesting.

// File: rtl/aps_pkg.sv
package aps_pkg;
    typedef logic [7:0] prio_t;
    typedef logic [9:0] intid_t;
    typedef logic [2:0] bp_t;
    typedef logic [8:0] run_t;

    localparam intid_t ID_SPURIOUS = 10'd1023;
    localparam intid_t ID_LIMIT    = 10'd1020;
    localparam run_t   RUN_IDLE    = 9'h100;

    function automatic prio_t group_prio(prio_t p, bp_t bp);
        prio_t m;
        m = 8'hFF << ({1'b0, bp} + 4'd1);
        return p & m;
    endfunction

    function automatic bp_t clamp_bp(logic [2:0] v, bp_t floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction
endpackage

// File: rtl/aps_lsb_find.sv
module aps_lsb_find #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/aps_grouper.sv
module aps_grouper
    import aps_pkg::*;
#(
    parameter int MIN_BPR = 3,
    parameter int LW      = 4
) (
    input  prio_t         prio,
    input  logic          grp_raw,
    input  logic          groups_en,
    input  logic          cbpr,
    input  bp_t           bpr,
    input  bp_t           abpr,
    output logic          grp_eff,
    output prio_t         gprio,
    output logic [LW-1:0] level
);
    localparam int SHIFT = MIN_BPR + 1;
    bp_t bp_use;

    always_comb begin
        grp_eff = groups_en & grp_raw;
        bp_use  = (grp_eff && !cbpr) ? abpr : bpr;
        gprio   = group_prio(prio, bp_use);
        level   = LW'(gprio >> SHIFT);
    end
endmodule

// File: rtl/active_prio_stack.sv
module active_prio_stack
    import aps_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int MIN_BPR = 3,
    parameter int LEVELS  = 256 >> (MIN_BPR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              groups_en,
    input  logic              cbpr,
    input  logic              ack_req,
    input  logic [9:0]        pend_id,
    input  logic [7:0]        pend_prio,
    input  logic              pend_grp,
    output logic [9:0]        ack_id,
    input  logic              eoi_req,
    input  logic [31:0]       eoi_data,
    input  logic              eoi_grp,
    input  logic              bp_we,
    input  logic              bp_sel,
    input  logic [31:0]       bp_wdata,
    output logic [8:0]        run_prio,
    output logic [2:0]        bpr_cur,
    output logic [2:0]        abpr_cur,
    output logic [LEVELS-1:0] act_g0,
    output logic [LEVELS-1:0] act_g1
);
    localparam int  SHIFT    = MIN_BPR + 1;
    localparam int  LW       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam bp_t BP_MIN   = bp_t'(MIN_BPR);
    localparam bp_t ABP_MIN  = (MIN_BPR >= 7) ? 3'd7 : bp_t'(MIN_BPR + 1);

    typedef struct packed {
        bp_t               bpr;
        bp_t               abpr;
        logic [LEVELS-1:0] a0;
        logic [LEVELS-1:0] a1;
        run_t              run;
    } st_t;

    st_t st_q, st_d;

    logic          ack_grp;
    prio_t         ack_gprio;
    logic [LW-1:0] ack_level;
    logic          acc_ok, eoi_ok, eoi_g;
    intid_t        eoi_id;
    logic [LEVELS-1:0] eoi_a0, eoi_a1;
    logic          eoi_any, cur_any;
    logic [LW-1:0] eoi_idx, cur_idx;

    aps_grouper #(.MIN_BPR(MIN_BPR), .LW(LW)) u_grp (
        .prio(pend_prio), .grp_raw(pend_grp), .groups_en(groups_en),
        .cbpr(cbpr), .bpr(st_q.bpr), .abpr(st_q.abpr),
        .grp_eff(ack_grp), .gprio(ack_gprio), .level(ack_level)
    );

    // lowest active level after a completion
    aps_lsb_find #(.W(LEVELS), .IW(LW)) u_eoi_lsb (
        .vec(eoi_a0 | eoi_a1), .any(eoi_any), .idx(eoi_idx)
    );

    // lowest active level of the present state, used by the checker below
    aps_lsb_find #(.W(LEVELS), .IW(LW)) u_cur_lsb (
        .vec(st_q.a0 | st_q.a1), .any(cur_any), .idx(cur_idx)
    );

    always_comb begin
        eoi_id = eoi_data[9:0];
        eoi_g  = groups_en & eoi_grp;
        eoi_a0 = st_q.a0;
        eoi_a1 = st_q.a1;
        if (eoi_g) eoi_a1 = st_q.a1 & (st_q.a1 - LEVELS'(1));
        else       eoi_a0 = st_q.a0 & (st_q.a0 - LEVELS'(1));
    end

    always_comb begin
        st_d   = st_q;
        acc_ok = ack_req && (pend_id < ID_LIMIT) && ({1'b0, pend_prio} < st_q.run);
        eoi_ok = eoi_req && !ack_req && (int'(eoi_id) < NUM_SRC) && (st_q.run != RUN_IDLE);
        ack_id = acc_ok ? pend_id : ID_SPURIOUS;

        if (acc_ok) begin
            if (ack_grp) st_d.a1[ack_level] = 1'b1;
            else         st_d.a0[ack_level] = 1'b1;
            st_d.run = {1'b0, ack_gprio};
        end else if (eoi_ok) begin
            st_d.a0  = eoi_a0;
            st_d.a1  = eoi_a1;
            st_d.run = eoi_any ? (run_t'(eoi_idx) << SHIFT) : RUN_IDLE;
        end

        if (bp_we) begin
            if (bp_sel) st_d.abpr = clamp_bp(bp_wdata[2:0], ABP_MIN);
            else        st_d.bpr  = clamp_bp(bp_wdata[2:0], BP_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bpr  <= BP_MIN;
            st_q.abpr <= ABP_MIN;
            st_q.a0   <= '0;
            st_q.a1   <= '0;
            st_q.run  <= RUN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_prio = st_q.run;
    assign bpr_cur  = st_q.bpr;
    assign abpr_cur = st_q.abpr;
    assign act_g0   = st_q.a0;
    assign act_g1   = st_q.a1;

    a_r7_run_tracks_bitmaps: assert property (@(posedge clk) disable iff (!rst_n)
        run_prio == (cur_any ? (run_t'(cur_idx) << SHIFT) : RUN_IDLE));

    a_r3_refused_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_id == ID_SPURIOUS) |=>
            ($stable(run_prio) && $stable(act_g0) && $stable(act_g1)));

    a_r2_accept_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_id != ID_SPURIOUS) |=> (run_prio < $past(run_prio)));

    a_r8_idle_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && run_prio == RUN_IDLE) |=>
            ($stable(act_g0) && $stable(act_g1) && run_prio == RUN_IDLE));

    a_r6_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_ok && (eoi_g ? |act_g1 : |act_g0)) |=>
            ($countones({act_g1, act_g0}) + 1 == $past($countones({act_g1, act_g0}))));

    a_r9_bp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (bpr_cur >= BP_MIN) && (abpr_cur >= ABP_MIN));
endmodule

// File: tb/active_prio_stack_test.sv
module active_prio_stack_test;
    localparam int NSRC = 96;
    localparam int MINB = 3;
    localparam int SH   = MINB + 1;
    localparam int LV   = 256 >> SH;

    logic clk = 0, rst_n = 0;
    logic groups_en = 0, cbpr = 0, ack_req = 0, pend_grp = 0;
    logic [9:0] pend_id = 0;
    logic [7:0] pend_prio = 0;
    logic [9:0] ack_id;
    logic eoi_req = 0, eoi_grp = 0, bp_we = 0, bp_sel = 0;
    logic [31:0] eoi_data = 0, bp_wdata = 0;
    logic [8:0] run_prio;
    logic [2:0] bpr_cur, abpr_cur;
    logic [LV-1:0] act_g0, act_g1;

    int nchk = 0, nerr = 0;
    logic [2:0] m_bpr, m_abpr;
    logic [LV-1:0] m_a0, m_a1;
    logic [8:0] m_run;

    always #5 clk = ~clk;

    active_prio_stack #(.NUM_SRC(NSRC), .MIN_BPR(MINB)) uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] model_lowest(logic [LV-1:0] v);
        for (int i = 0; i < LV; i++) if (v[i]) return 9'(i * (1 << SH));
        return 9'h100;
    endfunction

    task automatic check_state(string tag);
        check({tag, " run"}, 32'(run_prio), 32'(m_run));
        check({tag, " g0"},  32'(act_g0),   32'(m_a0));
        check({tag, " g1"},  32'(act_g1),   32'(m_a1));
        check({tag, " bpr"}, 32'(bpr_cur),  32'(m_bpr));
        check({tag, " abpr"},32'(abpr_cur), 32'(m_abpr));
    endtask

    task automatic op(string tag, bit a, int pid, int pp, bit pg,
                      bit e, int ed, bit eg, bit bw, bit bs, int bd);
        bit acc, g, eg2;
        int bp, gp, lvl, v;
        logic [7:0] mask;
        @(negedge clk);
        ack_req = a; pend_id = 10'(pid); pend_prio = 8'(pp); pend_grp = pg;
        eoi_req = e; eoi_data = 32'(ed); eoi_grp = eg;
        bp_we = bw; bp_sel = bs; bp_wdata = 32'(bd);
        #2;
        acc = a && pid < 1020 && pp < int'(m_run);
        check({tag, " ack_id"}, 32'(ack_id), acc ? 32'(pid) : 32'd1023);
        if (acc) begin
            g = groups_en && pg;
            bp = (g && !cbpr) ? m_abpr : m_bpr;
            mask = 8'((255 << (bp + 1)) & 255);
            gp = pp & mask;
            lvl = gp >> SH;
            if (g) m_a1[lvl] = 1'b1; else m_a0[lvl] = 1'b1;
            m_run = 9'(gp);
        end else if (e && !a && (ed & 1023) < NSRC && m_run != 9'h100) begin
            eg2 = groups_en && eg;
            if (eg2) m_a1 = m_a1 & (m_a1 - 1'b1);
            else     m_a0 = m_a0 & (m_a0 - 1'b1);
            m_run = model_lowest(m_a0 | m_a1);
        end
        if (bw) begin
            v = bd & 7;
            if (bs) m_abpr = 3'((v < MINB + 1) ? MINB + 1 : v);
            else    m_bpr  = 3'((v < MINB) ? MINB : v);
        end
        @(negedge clk);
        ack_req = 0; eoi_req = 0; bp_we = 0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_bpr = 3'(MINB); m_abpr = 3'(MINB + 1); m_a0 = 0; m_a1 = 0; m_run = 9'h100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset");
        check("R3 idle ack_id", 32'(ack_id), 32'd1023);

        groups_en = 1; cbpr = 0;
        op("R2 first ack",       1, 5, 8'h57, 0, 0, 0, 0, 0, 0, 0);
        op("R3 equal prio",      1, 7, 8'h50, 1, 0, 0, 0, 0, 0, 0);
        op("R3 id 1020",         1, 1020, 0, 0, 0, 0, 0, 0, 0, 0);
        op("R3 id 1023",         1, 1023, 0, 1, 0, 0, 0, 0, 0, 0);
        op("R4 group1 point",    1, 8, 8'h3F, 1, 0, 0, 0, 0, 0, 0);
        op("R8 eoi id NUM_SRC",  0, 0, 0, 0, 1, NSRC, 0, 0, 0, 0);
        op("R10 ack with eoi",   1, 9, 8'h05, 0, 1, 9, 0, 0, 0, 0);
        op("R6 eoi g0",          0, 0, 0, 0, 1, 32'hFFFF_FC09, 0, 0, 0, 0);
        op("R7 eoi g1",          0, 0, 0, 0, 1, 8, 1, 0, 0, 0);
        op("R7 eoi last",        0, 0, 0, 0, 1, 5, 0, 0, 0, 0);
        op("R8 eoi idle",        0, 0, 0, 0, 1, 3, 0, 0, 0, 0);
        op("R9 common clamp",    0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        op("R9 alias clamp",     0, 0, 0, 0, 0, 0, 0, 1, 1, 9);
        op("R9 alias seven",     0, 0, 0, 0, 0, 0, 0, 1, 1, 7);
        cbpr = 1;
        op("R4 cbpr forces",     1, 1, 8'h7F, 1, 0, 0, 0, 0, 0, 0);
        op("R6 eoi after cbpr",  0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
        cbpr = 0; groups_en = 0;
        op("R5 no groups ack",   1, 2, 8'h33, 1, 0, 0, 0, 0, 0, 0);
        op("R5 no groups eoi",   0, 0, 0, 0, 1, 2, 1, 0, 0, 0);
        groups_en = 1;
        op("R4 bp seven",        0, 0, 0, 0, 0, 0, 0, 1, 0, 7);
        op("R4 bp seven ack",    1, 4, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
        op("R6 bp seven eoi",    0, 0, 0, 0, 1, 4, 0, 0, 0, 0);
        op("R9 common back",     0, 0, 0, 0, 0, 0, 0, 1, 0, 3);
        op("R9 alias back",      0, 0, 0, 0, 0, 0, 0, 1, 1, 4);

        for (int n = 0; n < 1500; n++) begin
            int k, pid, ed;
            k = int'($urandom_range(0, 99));
            pid = ($urandom_range(0, 15) == 0) ? int'($urandom_range(1020, 1023))
                                               : int'($urandom_range(0, 1019));
            ed = ($urandom_range(0, 9) == 0) ? int'($urandom_range(NSRC, 1023))
                                             : int'($urandom_range(0, NSRC - 1));
            ed = ed | int'($urandom_range(0, 3) << 10);
            if (k < 45)
                op("R2 rand ack", 1, pid, int'($urandom_range(0, 255)), 1'($urandom), 0, 0, 0, 0, 0, 0);
            else if (k < 82)
                op("R6 rand eoi", 0, 0, 0, 0, 1, ed, 1'($urandom), 0, 0, 0);
            else if (k < 90)
                op("R10 rand both", 1, pid, int'($urandom_range(0, 255)), 1'($urandom), 1, ed, 1'($urandom), 0, 0, 0);
            else if (k < 95)
                op("R9 rand bp", 0, 0, 0, 0, 0, 0, 0, 1, 1'($urandom), int'($urandom));
            else begin
                @(negedge clk);
                groups_en = 1'($urandom); cbpr = 1'($urandom);
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule